// File: doc/BRIEF.md
# Daisy-Chained Interrupt Acknowledge Controller

This block is the interrupt-acknowledge front end of a two-channel peripheral that shares one multiplexed address/data bus with its host. It collects request pulses from a fixed set of internal sources, keeps a pending bit for each, and asks for service on an active-low request line. Priority across several devices on the same bus is settled by an enable-in/enable-out chain. Inside the device, priority is fixed, and a lower source index wins.

Request pulses are held in a staging register and only become pending when the address strobe falls. In an acknowledge cycle the host drives the acknowledge qualifier low and then pulses the data strobe. On the first falling edge of the data strobe, the device claims the cycle if the chain enable is high and a source is eligible. It then marks that source as under service, drops its request, and returns an 8-bit vector on the bus. A control input can suppress the vector. An end-of-interrupt pulse retires the highest-priority source that is under service.

Top module: `irq_ack_ctrl`

## Requirements
- R1: A synchronous active-low reset clears all staged, pending and under-service state: irq_n reads 1, vec_oe reads 0, and ieo follows iei.
- R2: A request pulse on src_req is held and becomes pending only at the next falling edge of as_n. irq_n stays 1 until that edge and goes to 0 in the cycle after it.
- R3: The device claims an acknowledge cycle only on a falling edge of ds_n while ack_n is 0, iei is 1 and at least one source is eligible. Otherwise no source is marked under service and no vector is driven.
- R4: Source 0 has the highest priority. A pending source is eligible only while no source of the same or a lower index is under service. A claimed cycle marks exactly one source, the lowest-index eligible one, as under service.
- R5: After a claimed cycle with vec_off at 0, vec_oe is 1 from the next clock edge until ds_n or ack_n returns high. During that time vec_out carries BASE_VEC with its low bits replaced by the served source index (default: 8'hA0 | index).
- R6: With vec_off at 1, a claimed cycle still marks the source as under service, but vec_oe stays 0.
- R7: irq_n is 1 in the cycle after a claimed data-strobe falling edge, unless a higher-priority request becomes pending in that same cycle.
- R8: ieo is 0 whenever iei is 0, any source is under service, or ack_n is 0 while a source is eligible. Otherwise ieo equals iei.
- R9: Only the first falling edge of ds_n inside one low period of ack_n can claim the cycle. A later edge in the same period is ignored, even if the conditions of R3 then hold.
- R10: A one-cycle eoi pulse clears only the lowest-index under-service bit. This can make lower-priority pending sources eligible again and raise ieo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bus strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| as_n | input | 1 | Address strobe, active low; its falling edge loads the pending bits |
| ds_n | input | 1 | Data strobe, active low; its falling edge may claim an acknowledge cycle |
| ack_n | input | 1 | Acknowledge qualifier, active low |
| iei | input | 1 | Chain enable in from the higher-priority neighbour |
| src_req | input | NUM_SRC | Per-source request pulses, bit 0 highest priority |
| vec_off | input | 1 | When 1, no vector is driven in a claimed cycle |
| eoi | input | 1 | End-of-interrupt pulse |
| irq_n | output | 1 | Interrupt request, active low |
| ieo | output | 1 | Chain enable out to the lower-priority neighbour |
| vec_out | output | VEC_W | Interrupt vector |
| vec_oe | output | 1 | Bus drive enable for vec_out |

## Verification
The hardest case to reach from the ports is a second data-strobe falling edge inside one acknowledge period. The first edge must not claim the cycle, and the second edge would claim it if it were honoured. The bench gets there by holding iei low at the first falling edge of ds_n, releasing ds_n, and then raising iei before a second falling edge while ack_n stays low. It then checks that no vector appears and that the request line stays asserted. The priority-blocking cases are set up by loading a lower-priority request while a higher-priority source is still under service, so that the request line stays high until an end-of-interrupt pulse.

// File: rtl/irq_ack_pkg.sv
// Package: shared helpers for the interrupt acknowledge controller.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package irq_ack_pkg;

    // Width of a source index; at least one bit even for a single source.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/strobe_fall.sv
// Module: falling-edge detector for one active-low bus strobe.
// Assumes: the strobe is already synchronous to clk; the idle level is high.
module strobe_fall (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic fall
);
    logic last_q;

    // Remember the strobe level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= strobe_n;
    end

    assign fall = last_q & ~strobe_n;
endmodule

// File: rtl/prio_pick.sv
// Module: fixed-priority picker, lowest index wins.
// Assumes: IW is wide enough to hold N-1.
module prio_pick #(
    parameter int N  = 6,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  onehot,
    output logic [IW-1:0] idx,
    output logic          any
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign seen[i+1]  = seen[i] | req[i];
        assign onehot[i]  = req[i] & ~seen[i];
    end
    assign any = seen[N];

    // Encode the one-hot winner into a binary index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++)
            if (onehot[i]) idx = idx | IW'(i);
    end
endmodule

// File: rtl/irq_pend_bank.sv
// Module: staged, pending and under-service bits for all sources.
// Assumes: grant_oh is one-hot or zero; eoi is a single-cycle pulse.
module irq_pend_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_req,
    input  logic         as_fall,
    input  logic [N-1:0] grant_oh,
    input  logic         eoi,
    output logic [N-1:0] ius,
    output logic [N-1:0] elig
);
    logic [N-1:0] stage_q;
    logic [N-1:0] pend_q;
    logic [N-1:0] retire_oh;
    logic [N:0]   svc_seen;

    assign svc_seen[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_mask
        assign svc_seen[i+1] = svc_seen[i] | ius[i];
        assign elig[i]       = pend_q[i] & ~svc_seen[i+1];
        assign retire_oh[i]  = ius[i] & ~svc_seen[i];
    end

    // Stage requests and move them to pending on an address-strobe fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            pend_q  <= '0;
        end else if (as_fall) begin
            stage_q <= '0;
            pend_q  <= (pend_q | stage_q | src_req) & ~grant_oh;
        end else begin
            stage_q <= stage_q | src_req;
            pend_q  <= pend_q & ~grant_oh;
        end
    end

    // Set under-service on a grant and retire the top one on end-of-interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) ius <= '0;
        else        ius <= (ius | grant_oh) & ~(eoi ? retire_oh : '0);
    end
endmodule

// File: rtl/irq_ack_ctrl.sv
// Module: top of the daisy-chained interrupt acknowledge controller.
// Assumes: bus strobes are synchronous to clk; one acknowledge period is
// bounded by ack_n low; vector low bits carry the served source index.
module irq_ack_ctrl
    import irq_ack_pkg::*;
#(
    parameter int                NUM_SRC  = 6,
    parameter int                VEC_W    = 8,
    parameter logic [VEC_W-1:0]  BASE_VEC = 8'hA0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               as_n,
    input  logic               ds_n,
    input  logic               ack_n,
    input  logic               iei,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               vec_off,
    input  logic               eoi,
    output logic               irq_n,
    output logic               ieo,
    output logic [VEC_W-1:0]   vec_out,
    output logic               vec_oe
);
    localparam int IDX_W = idx_width(NUM_SRC);

    logic               as_fall;
    logic               ds_fall;
    logic [NUM_SRC-1:0] ius;
    logic [NUM_SRC-1:0] elig;
    logic [NUM_SRC-1:0] win_oh;
    logic [NUM_SRC-1:0] grant_oh;
    logic [IDX_W-1:0]   win_idx;
    logic               any_elig;
    logic               ack_busy;
    logic               grant_stb;

    strobe_fall u_as (.clk(clk), .rst_n(rst_n), .strobe_n(as_n), .fall(as_fall));
    strobe_fall u_ds (.clk(clk), .rst_n(rst_n), .strobe_n(ds_n), .fall(ds_fall));

    prio_pick #(.N(NUM_SRC), .IW(IDX_W)) u_pick (
        .req(elig), .onehot(win_oh), .idx(win_idx), .any(any_elig)
    );

    irq_pend_bank #(.N(NUM_SRC)) u_bank (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .as_fall(as_fall),
        .grant_oh(grant_oh), .eoi(eoi), .ius(ius), .elig(elig)
    );

    assign grant_stb = ds_fall & ~ack_n & iei & any_elig & ~ack_busy;
    assign grant_oh  = grant_stb ? win_oh : '0;

    // Mark the acknowledge period as used after its first data-strobe fall.
    always_ff @(posedge clk) begin
        if (!rst_n || ack_n) ack_busy <= 1'b0;
        else if (ds_fall)    ack_busy <= 1'b1;
    end

    // Capture the vector for the granted source.
    always_ff @(posedge clk) begin
        if (!rst_n)         vec_out <= '0;
        else if (grant_stb) vec_out <= {BASE_VEC[VEC_W-1:IDX_W], win_idx};
    end

    // Drive the bus from the grant until the strobe or qualifier releases.
    always_ff @(posedge clk) begin
        if (!rst_n)         vec_oe <= 1'b0;
        else if (grant_stb) vec_oe <= ~vec_off;
        else                vec_oe <= vec_oe & ~ds_n & ~ack_n;
    end

    assign irq_n = ~any_elig;
    assign ieo   = iei & ~(|ius) & ~(~ack_n & any_elig);
endmodule

// File: rtl/irq_ack_ctrl_chk.sv
// Module: property checker for irq_ack_ctrl, attached by bind.
// Assumes: ius and the strobe/grant pulses are reachable in the top scope.
module irq_ack_ctrl_chk #(
    parameter int N = 6
) (
    input logic         clk,
    input logic         rst_n,
    input logic         as_fall,
    input logic         eoi,
    input logic         grant_stb,
    input logic         iei,
    input logic         ack_n,
    input logic         irq_n,
    input logic         ieo,
    input logic         vec_oe,
    input logic         vec_off,
    input logic [N-1:0] ius
);
    p_req_on_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> ($past(as_fall) || $past(eoi)));

    p_claim_needs_chain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ius) > $past($countones(ius))) |-> $past(iei && !ack_n && !irq_n));

    p_single_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ius) <= $past($countones(ius)) + 1);

    p_no_vec_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_oe) |-> !$past(vec_off));

    p_irq_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (($countones(ius) > $past($countones(ius))) && !$past(as_fall)) |-> irq_n);

    p_ieo_in_service_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|ius || !iei) |-> !ieo);

    p_eoi_retires_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && |ius && !grant_stb) |=> $countones(ius) == $past($countones(ius)) - 1);
endmodule

bind irq_ack_ctrl irq_ack_ctrl_chk #(.N(NUM_SRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .as_fall(as_fall), .eoi(eoi),
    .grant_stb(grant_stb), .iei(iei), .ack_n(ack_n), .irq_n(irq_n),
    .ieo(ieo), .vec_oe(vec_oe), .vec_off(vec_off), .ius(ius)
);

// File: tb/irq_ack_ctrl_test.sv
module irq_ack_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          as_n = 1'b1, ds_n = 1'b1, ack_n = 1'b1, iei = 1'b1;
    logic [NS-1:0] src_req = '0;
    logic          vec_off = 1'b0, eoi = 1'b0;
    logic          irq_n, ieo, vec_oe;
    logic [7:0]    vec_out;
    int            checks = 0, errors = 0;
    bit            finished = 0;

    irq_ack_ctrl uut (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .ds_n(ds_n), .ack_n(ack_n),
        .iei(iei), .src_req(src_req), .vec_off(vec_off), .eoi(eoi),
        .irq_n(irq_n), .ieo(ieo), .vec_out(vec_out), .vec_oe(vec_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask

    task automatic pulse_req(input logic [NS-1:0] v);
        src_req = v; tick(); src_req = '0;
    endtask

    task automatic strobe_as();
        as_n = 1'b0; tick(); as_n = 1'b1; tick();
    endtask

    task automatic pulse_eoi();
        eoi = 1'b1; tick(); eoi = 1'b0;
    endtask

    // One acknowledge period with one data strobe; checks vector and request.
    task automatic ack_cycle(input string req, input logic exp_oe,
                             input logic [7:0] exp_vec, input logic exp_irq);
        ack_n = 1'b0; tick();
        ds_n = 1'b0; tick();
        chk({req, " vec_oe"}, vec_oe, exp_oe);
        if (exp_oe) chk({req, " vec_out"}, vec_out, exp_vec);
        chk({req, " irq_n"}, irq_n, exp_irq);
        ds_n = 1'b1; ack_n = 1'b1; tick();
        chk({req, " vec_oe released"}, vec_oe, 1'b0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; tick();
        chk("R1 irq_n", irq_n, 1'b1);
        chk("R1 vec_oe", vec_oe, 1'b0);
        chk("R1 ieo", ieo, 1'b1);
    endtask

    task automatic t_strobe_gate();
        pulse_req(6'b000100); tick(); tick();
        chk("R2 held until strobe", irq_n, 1'b1);
        strobe_as();
        chk("R2 pending after strobe", irq_n, 1'b0);
        chk("R8 ieo idle pending", ieo, 1'b1);
    endtask

    task automatic t_basic_ack();
        ack_n = 1'b0; tick();
        chk("R8 ieo low pending+ack", ieo, 1'b0);
        ds_n = 1'b0; tick();
        chk("R5 vec_oe", vec_oe, 1'b1);
        chk("R5 vec_out", vec_out, 8'hA2);
        chk("R7 irq_n released", irq_n, 1'b1);
        ds_n = 1'b1; ack_n = 1'b1; tick();
        chk("R5 vec_oe drop", vec_oe, 1'b0);
        chk("R8 ieo low in service", ieo, 1'b0);
    endtask

    task automatic t_block_eoi();
        pulse_req(6'b010000); strobe_as();
        chk("R4 lower blocked", irq_n, 1'b1);
        pulse_eoi();
        chk("R10 lower re-enabled", irq_n, 1'b0);
        chk("R10 ieo back", ieo, 1'b1);
    endtask

    task automatic t_first_ds_only();
        ack_n = 1'b0; iei = 1'b0; tick();
        ds_n = 1'b0; tick();
        chk("R3 no claim iei low", vec_oe, 1'b0);
        chk("R3 irq kept", irq_n, 1'b0);
        chk("R8 ieo iei low", ieo, 1'b0);
        ds_n = 1'b1; iei = 1'b1; tick();
        ds_n = 1'b0; tick();
        chk("R9 second ds ignored vec", vec_oe, 1'b0);
        chk("R9 second ds ignored irq", irq_n, 1'b0);
        ds_n = 1'b1; ack_n = 1'b1; tick();
    endtask

    task automatic t_vec_off();
        vec_off = 1'b1;
        ack_cycle("R6", 1'b0, 8'h00, 1'b1);
        vec_off = 1'b0;
        pulse_eoi();
        chk("R10 nothing left", irq_n, 1'b1);
        chk("R10 ieo free", ieo, 1'b1);
    endtask

    task automatic t_priority();
        pulse_req(6'b100001); strobe_as();
        ack_cycle("R4 src0 first", 1'b1, 8'hA0, 1'b1);
        pulse_eoi();
        chk("R4 src5 eligible", irq_n, 1'b0);
        ack_cycle("R4 src5 next", 1'b1, 8'hA5, 1'b1);
        pulse_eoi();
        chk("R10 all retired", ieo, 1'b1);
    endtask

    task automatic t_reset_clears();
        pulse_req(6'b001000); strobe_as();
        chk("R2 src3 pending", irq_n, 1'b0);
        rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
        chk("R1 pending cleared", irq_n, 1'b1);
        chk("R1 ieo after reset", ieo, 1'b1);
    endtask

    initial begin
        tick();
        t_reset();
        t_strobe_gate();
        t_basic_ack();
        t_block_eoi();
        t_first_ds_only();
        t_vec_off();
        t_priority();
        t_reset_clears();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule